// File: doc/BRIEF.md
# Ping-Pong Descriptor DMA Channel

This block is one DMA channel that copies a single data item from a peripheral data port to a target address each time a request is accepted. The target is either a register file or a memory space, chosen by one space select bit that applies to the whole channel. Two descriptors, table 0 and table 1, each hold a transfer count and an address pointer. Each finished transfer moves the active pointer up by one and the active count down by one. When the count reaches zero, that table's block is complete.

Requests are not looked at on every cycle. A free-running phase counter opens a sample point once every `SAMPLE_PERIOD` cycles, and a transfer can start only at one of these points. It starts only if the channel is enabled, a request is present or pending, the arbitration grant is high and the active count is nonzero. A register-file transfer holds the bus for a fixed number of cycles. A memory transfer holds it for a longer fixed number of cycles, stretched by one cycle for every cycle that the wait input is high.

At the end of a block the channel raises its end-of-block flag. If swap mode is on, the channel switches to the other table and stays enabled, so a peripheral can fill two buffers in turn. If swap mode is off, the channel disables itself.

Top module: `pp_dma_channel`

## Requirements
- R1: A transfer starts only on a sample point. The sample phase counter restarts at reset, so the first sample point is the fifth rising edge after reset is released, and later ones follow every 5 cycles. An enabled, granted channel with a pending request and an idle bus starts within 5 cycles.
- R2: A request seen at a sample point while `grant_i` is low starts nothing and stays pending. It starts at the first sample point where `grant_i` is high.
- R3: With `space_i` = 0 (register file), `bus_req_o` stays high for exactly 8 cycles per transfer, and `bus_wait_i` has no effect on this.
- R4: With `space_i` = 1 (memory), `bus_req_o` stays high for 16 cycles plus one cycle for each cycle in which `bus_wait_i` is high during the transfer.
- R5: A transfer drives `bus_addr_o` with the active table's pointer and `bus_data_o` with `periph_data_i` as captured at the start edge. On completion the pointer increments and the count decrements. A table whose count is zero starts no transfer.
- R6: When swap mode is on (`swap_en_i` = 1) at an end of block, `active_tbl_o` toggles and `en_o` stays 1.
- R7: Every end of block sets `eob_irq_o`. A pulse on `eob_clr_i` clears it, and a new end of block in the same cycle takes priority over the clear.
- R8: When swap mode is off at an end of block, `en_o` drops to 0, the active table is unchanged, and requests start nothing until `en_set_i` is pulsed.
- R9: After reset, `en_o` = 0, `active_tbl_o` = 0, `eob_irq_o` = 0 and `bus_req_o` = 0.
- R10: A one-cycle request that arrives while a transfer is running is held. It starts a transfer at a later sample point after the current one completes.
- R11: While swap mode stays on, successive blocks alternate table 0, table 1, table 0. The first end of block after swap mode is turned off disables the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Peripheral request |
| grant_i | input | 1 | Arbitration permits a start |
| periph_data_i | input | DATA_W | Peripheral data item |
| en_set_i | input | 1 | Pulse: enable channel |
| en_clr_i | input | 1 | Pulse: disable channel |
| swap_en_i | input | 1 | Swap mode enable |
| space_i | input | 1 | Target space, 0 register file, 1 memory |
| dsc_wr_i | input | 1 | Descriptor write strobe |
| dsc_tbl_i | input | 1 | Descriptor table selected for write |
| dsc_cnt_i | input | CNT_W | Count to write |
| dsc_ptr_i | input | ADDR_W | Pointer to write |
| eob_clr_i | input | 1 | Pulse: clear end-of-block flag (write one) |
| bus_wait_i | input | 1 | Wait state request from target |
| bus_req_o | output | 1 | Transfer holds the bus |
| bus_addr_o | output | ADDR_W | Target address |
| bus_data_o | output | DATA_W | Data written to target |
| bus_space_o | output | 1 | Space of current transfer |
| xfer_done_o | output | 1 | Last cycle of a transfer |
| en_o | output | 1 | Channel enable state |
| active_tbl_o | output | 1 | Active descriptor table |
| eob_irq_o | output | 1 | End-of-block interrupt flag |

## Verification
The hardest case to reach is a change of table with software involved. A refill of the idle table and a change of the swap bit must land while the other table is still streaming, so that the third end of block shows both the alternation and the final disable. The stimulus holds the request high over a chain of blocks and waits for each end-of-block flag. It then clears the flag, reloads table 0 during table 1's block, and turns swap mode off in the cycle after the second end of block. A second hard case is a request that exists only during a transfer. One-cycle request pulses are placed inside the bus-busy window to show that such a request is held pending.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
    parameter int ADDR_W = 8;
    parameter int CNT_W  = 8;

    typedef enum logic {
        SPACE_REG = 1'b0,
        SPACE_MEM = 1'b1
    } space_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } xfer_st_e;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] ptr;
    } desc_t;

    function automatic int unsigned max_cycles(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/pp_dma_sampler.sv
module pp_dma_sampler #(
    parameter int PERIOD = 5
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [PW-1:0] phase_q;

    assign tick = (phase_q == PW'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (rst)       phase_q <= '0;
        else if (tick) phase_q <= '0;
        else           phase_q <= phase_q + 1'b1;
    end
endmodule

// File: rtl/pp_dma_desc.sv
module pp_dma_desc
    import pp_dma_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  logic  wr_tbl,
    input  desc_t wr_desc,
    input  logic  adv,
    input  logic  swap_en,
    output desc_t act_desc,
    output logic  act_tbl,
    output logic  eob
);
    desc_t tbl_q [2];

    assign act_desc = tbl_q[act_tbl];
    assign eob      = adv && (act_desc.cnt == CNT_W'(1));

    for (genvar g = 0; g < 2; g++) begin : g_tbl
        desc_t q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (adv && (act_tbl == 1'(g))) begin
                q.cnt <= q.cnt - 1'b1;
                q.ptr <= q.ptr + 1'b1;
            end else if (wr && (wr_tbl == 1'(g))) begin
                q <= wr_desc;
            end
        end
        assign tbl_q[g] = q;
    end

    always_ff @(posedge clk) begin
        if (rst)                 act_tbl <= 1'b0;
        else if (eob && swap_en) act_tbl <= ~act_tbl;
    end
endmodule

// File: rtl/pp_dma_engine.sv
module pp_dma_engine
    import pp_dma_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int REG_CYCLES = 8,
    parameter int MEM_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              en,
    input  logic              req,
    input  logic              grant,
    input  desc_t             act_desc,
    input  space_e            space,
    input  logic              bus_wait,
    input  logic [DATA_W-1:0] periph_data,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data,
    output space_e            bus_space,
    output logic              done
);
    localparam int MAXC = int'(max_cycles(REG_CYCLES, MEM_CYCLES));
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;

    xfer_st_e          st_q;
    logic [CW-1:0]     cyc_q;
    logic [CW-1:0]     len_m1;
    logic              pend_q;
    logic              req_seen;
    logic              start;
    logic              stall;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    space_e            space_q;

    assign req_seen = pend_q | req;
    assign start    = (st_q == ST_IDLE) && tick && en && req_seen && grant
                      && (act_desc.cnt != '0);
    assign len_m1   = (space_q == SPACE_MEM) ? CW'(MEM_CYCLES - 1) : CW'(REG_CYCLES - 1);
    assign stall    = (st_q == ST_BUSY) && (space_q == SPACE_MEM) && bus_wait;
    assign done     = (st_q == ST_BUSY) && !stall && (cyc_q == len_m1);

    assign bus_req   = (st_q == ST_BUSY);
    assign bus_addr  = addr_q;
    assign bus_data  = data_q;
    assign bus_space = space_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            cyc_q   <= '0;
            pend_q  <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            space_q <= SPACE_REG;
        end else begin
            pend_q <= en ? (req_seen && !start) : 1'b0;
            if (start) begin
                st_q    <= ST_BUSY;
                cyc_q   <= '0;
                addr_q  <= act_desc.ptr;
                data_q  <= periph_data;
                space_q <= space;
            end else if (done) begin
                st_q <= ST_IDLE;
            end else if ((st_q == ST_BUSY) && !stall) begin
                cyc_q <= cyc_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pp_dma_channel.sv
module pp_dma_channel
    import pp_dma_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int SAMPLE_PERIOD = 5,
    parameter int REG_CYCLES    = 8,
    parameter int MEM_CYCLES    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic              grant_i,
    input  logic [DATA_W-1:0] periph_data_i,
    input  logic              en_set_i,
    input  logic              en_clr_i,
    input  logic              swap_en_i,
    input  logic              space_i,
    input  logic              dsc_wr_i,
    input  logic              dsc_tbl_i,
    input  logic [CNT_W-1:0]  dsc_cnt_i,
    input  logic [ADDR_W-1:0] dsc_ptr_i,
    input  logic              eob_clr_i,
    input  logic              bus_wait_i,
    output logic              bus_req_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_data_o,
    output logic              bus_space_o,
    output logic              xfer_done_o,
    output logic              en_o,
    output logic              active_tbl_o,
    output logic              eob_irq_o
);
    logic   tick;
    logic   eob;
    logic   en_q;
    logic   eob_q;
    desc_t  act_desc;
    desc_t  wr_desc;
    space_e bus_space;

    assign wr_desc.cnt = dsc_cnt_i;
    assign wr_desc.ptr = dsc_ptr_i;

    pp_dma_sampler #(.PERIOD(SAMPLE_PERIOD)) u_sampler (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    pp_dma_desc u_desc (
        .clk      (clk),
        .rst      (rst),
        .wr       (dsc_wr_i),
        .wr_tbl   (dsc_tbl_i),
        .wr_desc  (wr_desc),
        .adv      (xfer_done_o),
        .swap_en  (swap_en_i),
        .act_desc (act_desc),
        .act_tbl  (active_tbl_o),
        .eob      (eob)
    );

    pp_dma_engine #(
        .DATA_W     (DATA_W),
        .REG_CYCLES (REG_CYCLES),
        .MEM_CYCLES (MEM_CYCLES)
    ) u_engine (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .en          (en_q),
        .req         (req_i),
        .grant       (grant_i),
        .act_desc    (act_desc),
        .space       (space_e'(space_i)),
        .bus_wait    (bus_wait_i),
        .periph_data (periph_data_i),
        .bus_req     (bus_req_o),
        .bus_addr    (bus_addr_o),
        .bus_data    (bus_data_o),
        .bus_space   (bus_space),
        .done        (xfer_done_o)
    );

    assign bus_space_o = bus_space;

    always_ff @(posedge clk) begin
        if (rst)                     en_q <= 1'b0;
        else if (eob && !swap_en_i)  en_q <= 1'b0;
        else if (en_set_i)           en_q <= 1'b1;
        else if (en_clr_i)           en_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)            eob_q <= 1'b0;
        else if (eob)       eob_q <= 1'b1;
        else if (eob_clr_i) eob_q <= 1'b0;
    end

    assign en_o      = en_q;
    assign eob_irq_o = eob_q;
endmodule

// File: rtl/pp_dma_channel_chk.sv
module pp_dma_channel_chk #(
    parameter int SAMPLE_PERIOD = 5,
    parameter int REG_CYCLES    = 8,
    parameter int MEM_CYCLES    = 16
) (
    input logic clk,
    input logic rst,
    input logic grant_i,
    input logic swap_en_i,
    input logic bus_wait_i,
    input logic bus_req_o,
    input logic bus_space_o,
    input logic xfer_done_o,
    input logic en_o,
    input logic active_tbl_o,
    input logic eob_irq_o
);
    logic [7:0]  ph;
    logic [15:0] busy_cnt;
    logic [15:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= '0;
            busy_cnt <= '0;
            wait_cnt <= '0;
        end else begin
            ph       <= (ph == 8'(SAMPLE_PERIOD - 1)) ? 8'd0 : ph + 8'd1;
            busy_cnt <= bus_req_o ? busy_cnt + 16'd1 : 16'd0;
            wait_cnt <= !bus_req_o ? 16'd0 :
                        (bus_space_o && bus_wait_i) ? wait_cnt + 16'd1 : wait_cnt;
        end
    end

    // R1: starts fall on the sample grid counted from reset
    a_r1_grid: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req_o) |-> ($past(ph) == 8'(SAMPLE_PERIOD - 1)));

    // R2: a start needs the grant at the sample point
    a_r2_grant: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req_o) |-> $past(grant_i));

    // R3: register file transfer length
    a_r3_reg_len: assert property (@(posedge clk) disable iff (rst)
        (xfer_done_o && !bus_space_o) |-> (busy_cnt == 16'(REG_CYCLES - 1)));

    // R4: memory transfer length with wait states
    a_r4_mem_len: assert property (@(posedge clk) disable iff (rst)
        (xfer_done_o && bus_space_o) |-> (busy_cnt == 16'(MEM_CYCLES - 1) + wait_cnt));

    // R6: swap keeps the enable and toggles the table
    a_r6_swap_keep: assert property (@(posedge clk) disable iff (rst)
        ($rose(eob_irq_o) && $past(swap_en_i)) |->
        (en_o && (active_tbl_o != $past(active_tbl_o))));

    // R8: no swap disables the channel and keeps the table
    a_r8_stop: assert property (@(posedge clk) disable iff (rst)
        ($rose(eob_irq_o) && !$past(swap_en_i)) |->
        (!en_o && (active_tbl_o == $past(active_tbl_o))));
endmodule

bind pp_dma_channel pp_dma_channel_chk #(
    .SAMPLE_PERIOD (SAMPLE_PERIOD),
    .REG_CYCLES    (REG_CYCLES),
    .MEM_CYCLES    (MEM_CYCLES)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .grant_i      (grant_i),
    .swap_en_i    (swap_en_i),
    .bus_wait_i   (bus_wait_i),
    .bus_req_o    (bus_req_o),
    .bus_space_o  (bus_space_o),
    .xfer_done_o  (xfer_done_o),
    .en_o         (en_o),
    .active_tbl_o (active_tbl_o),
    .eob_irq_o    (eob_irq_o)
);

// File: tb/pp_dma_channel_test.sv
module pp_dma_channel_test;
    localparam int DW = 8;
    localparam logic [7:0] DBASE = 8'hC0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_i = 0, grant_i = 1, en_set_i = 0, en_clr_i = 0, swap_en_i = 0;
    logic space_i = 0, dsc_wr_i = 0, dsc_tbl_i = 0, eob_clr_i = 0, bus_wait_i = 0;
    logic [DW-1:0] periph_data_i = DBASE;
    logic [7:0] dsc_cnt_i = 0, dsc_ptr_i = 0;
    logic bus_req_o, bus_space_o, xfer_done_o, en_o, active_tbl_o, eob_irq_o;
    logic [7:0] bus_addr_o;
    logic [DW-1:0] bus_data_o;

    always #2 clk = ~clk;

    pp_dma_channel uut (
        .clk(clk), .rst(rst), .req_i(req_i), .grant_i(grant_i),
        .periph_data_i(periph_data_i), .en_set_i(en_set_i), .en_clr_i(en_clr_i),
        .swap_en_i(swap_en_i), .space_i(space_i), .dsc_wr_i(dsc_wr_i),
        .dsc_tbl_i(dsc_tbl_i), .dsc_cnt_i(dsc_cnt_i), .dsc_ptr_i(dsc_ptr_i),
        .eob_clr_i(eob_clr_i), .bus_wait_i(bus_wait_i), .bus_req_o(bus_req_o),
        .bus_addr_o(bus_addr_o), .bus_data_o(bus_data_o), .bus_space_o(bus_space_o),
        .xfer_done_o(xfer_done_o), .en_o(en_o), .active_tbl_o(active_tbl_o),
        .eob_irq_o(eob_irq_o)
    );

    int tests = 0, fails = 0;
    int cyc = 0;
    int nstart = 0, nlen = 0, blen = 0, wleft = 0, wait_plan = 0;
    bit wait_force = 0, prev = 0;
    int start_cyc [64];
    logic [7:0] start_addr [64];
    logic [7:0] start_data [64];
    int lens [64];

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (bus_req_o && !prev) begin
                start_cyc[nstart % 64]  = cyc;
                start_addr[nstart % 64] = bus_addr_o;
                start_data[nstart % 64] = bus_data_o;
                nstart = nstart + 1;
                periph_data_i = DBASE + 8'(nstart);
                blen  = 1;
                wleft = wait_plan;
            end else if (bus_req_o) begin
                blen = blen + 1;
            end else if (prev) begin
                lens[nlen % 64] = blen;
                nlen = nlen + 1;
            end
            prev = bus_req_o;
            if (bus_req_o && wleft > 0) begin
                bus_wait_i = 1'b1;
                wleft = wleft - 1;
            end else begin
                bus_wait_i = wait_force;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input bit t, input int c, input int p);
        @(negedge clk);
        dsc_wr_i = 1; dsc_tbl_i = t; dsc_cnt_i = 8'(c); dsc_ptr_i = 8'(p);
        @(negedge clk);
        dsc_wr_i = 0;
    endtask

    task automatic pulse_en;
        @(negedge clk); en_set_i = 1; @(negedge clk); en_set_i = 0;
    endtask

    task automatic clear_eob;
        @(negedge clk); eob_clr_i = 1; @(negedge clk); eob_clr_i = 0;
    endtask

    task automatic wait_eob(input string req, input int limit);
        int n = 0;
        while (!eob_irq_o && n < limit) begin @(negedge clk); n++; end
        check(eob_irq_o, req, int'(eob_irq_o), 1);
        tick(2);
    endtask

    task automatic wait_starts(input int target, input int limit, input string req);
        int n = 0;
        while (nstart < target && n < limit) begin @(negedge clk); n++; end
        check(nstart >= target, req, nstart, target);
    endtask

    initial begin
        #150000;
        fails++; tests++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int b, c0;
        tick(3);
        // R9 reset state
        check(en_o == 0, "R9 en", int'(en_o), 0);
        check(active_tbl_o == 0, "R9 table", int'(active_tbl_o), 0);
        check(eob_irq_o == 0, "R9 eob", int'(eob_irq_o), 0);
        check(bus_req_o == 0, "R9 busreq", int'(bus_req_o), 0);
        rst = 0;

        // register file stream, wait input held high and ignored
        space_i = 0; swap_en_i = 0; wait_force = 1;
        load(0, 4, 8'h20);
        pulse_en();
        b = nstart; c0 = cyc; req_i = 1;
        wait_eob("R7 eob reg", 400);
        check(nstart - b == 4, "R5 count", nstart - b, 4);
        check(start_cyc[b] - c0 <= 5, "R1 latency", start_cyc[b] - c0, 5);
        for (int k = 0; k < 4; k++) begin
            check(start_addr[b+k] == 8'(8'h20 + k), "R5 addr", start_addr[b+k], 8'h20 + k);
            check(start_data[b+k] == 8'(DBASE + 8'(b + k)), "R5 data", start_data[b+k], DBASE + b + k);
            check(lens[b+k] == 8, "R3 length", lens[b+k], 8);
            check(start_cyc[b+k] % 5 == 0, "R1 grid", start_cyc[b+k] % 5, 0);
        end
        check(en_o == 0, "R8 disabled", int'(en_o), 0);
        check(active_tbl_o == 0, "R8 table", int'(active_tbl_o), 0);
        b = nstart;
        tick(40);
        check(nstart == b, "R8 ignored", nstart - b, 0);
        req_i = 0; wait_force = 0;
        clear_eob();
        tick(1);
        check(eob_irq_o == 0, "R7 clear", int'(eob_irq_o), 1'b0);

        // memory sweep over wait counts
        space_i = 1;
        for (int w = 0; w < 4; w++) begin
            wait_plan = w;
            load(0, 1, 8'h80 + w);
            pulse_en();
            b = nstart; req_i = 1;
            wait_eob("R4 eob", 400);
            req_i = 0;
            check(nlen == nstart && lens[b] == 16 + w, "R4 length", lens[b], 16 + w);
            check(start_addr[b] == 8'(8'h80 + w), "R5 mem addr", start_addr[b], 8'h80 + w);
            clear_eob();
        end
        wait_plan = 0;
        space_i = 0;

        // grant gating
        grant_i = 0;
        load(0, 1, 8'h90);
        pulse_en();
        b = nstart; req_i = 1;
        tick(30);
        check(nstart == b, "R2 no grant", nstart - b, 0);
        c0 = cyc; grant_i = 1;
        wait_starts(b + 1, 20, "R2 granted");
        check(start_cyc[b] - c0 <= 5, "R2 latency", start_cyc[b] - c0, 5);
        wait_eob("R2 eob", 200);
        req_i = 0;
        clear_eob();

        // swap alternation
        load(0, 2, 8'h10);
        load(1, 3, 8'h40);
        swap_en_i = 1;
        pulse_en();
        b = nstart; req_i = 1;
        wait_eob("R6 eob1", 400);
        check(en_o == 1, "R6 en kept", int'(en_o), 1);
        check(active_tbl_o == 1, "R6 table1", int'(active_tbl_o), 1);
        clear_eob();
        load(0, 2, 8'h18);
        wait_eob("R11 eob2", 400);
        swap_en_i = 0;
        check(en_o == 1, "R11 en kept", int'(en_o), 1);
        check(active_tbl_o == 0, "R11 back to 0", int'(active_tbl_o), 0);
        clear_eob();
        wait_eob("R11 eob3", 400);
        req_i = 0;
        tick(2);
        check(en_o == 0, "R11 stop", int'(en_o), 0);
        check(active_tbl_o == 0, "R11 table", int'(active_tbl_o), 0);
        check(nstart - b == 7, "R11 count", nstart - b, 7);
        begin
            int exp_a [7] = '{8'h10, 8'h11, 8'h40, 8'h41, 8'h42, 8'h18, 8'h19};
            for (int k = 0; k < 7; k++)
                check(start_addr[b+k] == 8'(exp_a[k]), "R11 addr", start_addr[b+k], exp_a[k]);
        end
        clear_eob();

        // zero count starts nothing
        pulse_en();
        b = nstart; req_i = 1;
        tick(30);
        check(nstart == b, "R5 zero count", nstart - b, 0);
        req_i = 0;
        @(negedge clk); en_clr_i = 1; @(negedge clk); en_clr_i = 0;
        check(en_o == 0, "R8 en clear", int'(en_o), 0);

        // request held during a transfer
        load(0, 2, 8'h60);
        pulse_en();
        b = nstart;
        @(negedge clk); req_i = 1; @(negedge clk); req_i = 0;
        wait_starts(b + 1, 20, "R10 first");
        tick(2);
        req_i = 1; @(negedge clk); req_i = 0;
        wait_eob("R10 eob", 200);
        check(nstart - b == 2, "R10 held", nstart - b, 2);
        check(start_addr[b+1] == 8'h61, "R10 addr", start_addr[b+1], 8'h61);
        check(start_cyc[b+1] % 5 == 0, "R1 grid held", start_cyc[b+1] % 5, 0);
        b = nstart;
        tick(30);
        check(nstart == b, "R10 no extra", nstart - b, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule